// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a 3½-digit dual-slope integrating converter. An oscillator clock, divided by four, forms one count. The block steps through a measurement cycle of fixed length. The cycle has three phases. Signal integration runs for a fixed 1000 counts. Reference de-integration runs until the analog comparator reports a zero crossing. Auto-zero takes whatever counts remain in the 4000-count cycle. Three one-hot phase pins drive the analog switches.

A chain of four BCD decade stages counts during each phase. The chain is cleared when integration begins and again when de-integration begins. When de-integration ends, the count is moved into a display latch. The latch drives four BCD digit outputs and four seven-segment patterns. The top stage is a half digit that can show only a blank or a 1. If the comparator never trips within 2000 counts, the reading is flagged as overrange. An overrange display shows a lone 1 in the top place.

The results leave as plain held registers and not as a stream. They change once per cycle, and any reader samples them while auto-zero or integration is running, so there is no valid/ready handshake and no back-pressure. The sign bit comes from an input and is latched together with the digits.

Top module: `dsadc_sequencer`

## Requirements
- R1: While reset is held low and after its release, the block is in auto-zero (ph_az=1). digits=0, over_range=0 and sign_out=0. segs shows "0" on each of the three lower digits and a blank top digit.
- R2: Exactly one of ph_az, ph_int, ph_deint is high in every clock after reset. The phases always follow the order auto-zero, integrate, de-integrate, auto-zero.
- R3: One count equals four clocks. The integrate phase lasts exactly 1000 counts (4000 clocks), and the counter chain starts it from zero.
- R4: De-integration ends at the first count on which cmp_trip is sampled high. The latched reading N is the number of counts completed before that count. The phase lasts N+1 counts (4N+4 clocks), so readings run from 0 to 1999.
- R5: If cmp_trip is not seen by the 2000th de-integrate count, the phase ends after 2000 counts (8000 clocks) with over_range=1 and digits=16'h1000.
- R6: The full cycle, from one rise of ph_int to the next, is always 4000 counts (16000 clocks). Auto-zero absorbs the counts that de-integration did not use.
- R7: digits, sign_out and over_range change only at the end of de-integration. cmp_trip and sign_in have no effect during integrate or auto-zero.
- R8: sign_out takes the value of sign_in sampled at the count that ends de-integration.
- R9: Each segment group is 7 bits, with bit0=a through bit6=g, active high. Digits 0 to 9 use the patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F. The top group shows 06 for a 1 and 00 for a 0. While over_range=1, the three lower groups are 00.
- R10: digits packs units in [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12]. segs uses the same order in 7-bit groups, with units in [6:0]. Every digit stays in 0 to 9.
- R11: After reset is released, the first integrate phase starts exactly 4000 clocks later, after an initial auto-zero of 1000 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_trip | input | 1 | Comparator zero-crossing indication |
| sign_in | input | 1 | Polarity from the analog front end |
| ph_az | output | 1 | Auto-zero switch select |
| ph_int | output | 1 | Signal-integrate switch select |
| ph_deint | output | 1 | Reference de-integrate switch select |
| digits | output | 16 | Latched BCD reading, units in the low nibble |
| segs | output | 28 | Seven-segment patterns, 7 bits per digit |
| sign_out | output | 1 | Latched polarity |
| over_range | output | 1 | Latched overrange flag |

## Verification
The hardest cases to reach from the ports are the two ends of the de-integrate window. One is a trip on the very first count, which reads 0. The other is a trip on count 2000, which reads 1999 and must not be confused with an overrange. The bench counts clocks from the rise of ph_deint and raises cmp_trip at exactly 4N+1 clocks, so the trip lands on a chosen count. It mixes these directed ends with a no-trip cycle and random readings. During integrate and auto-zero it toggles cmp_trip and sign_in at random, which shows that the latch ignores them.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  // active-high segments, bit0 = a ... bit6 = g
  function automatic logic [6:0] seg7(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsadc_prescale.sv
module dsadc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3: a count never lasts a single clock
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dsadc_bcd_chain.sv
module dsadc_bcd_chain #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [4*NDIG-1:0] val
);
  logic [NDIG-1:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] d;

    if (i < NDIG - 1) begin : g_carry
      assign carry[i+1] = carry[i] && (d == 4'd9);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        d <= 4'd0;
      else if (clr)      d <= 4'd0;
      else if (carry[i]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
    end

    assign val[4*i +: 4] = d;

    // R10: each decade stays a legal BCD value
    assert_digit_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      d <= 4'd9);
  end
endmodule

// File: rtl/dsadc_seg_bank.sv
module dsadc_seg_bank
  import dsadc_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [4*NDIG-1:0] digits,
  input  logic              blank_low,
  output logic [7*NDIG-1:0] seg
);
  for (genvar i = 0; i < NDIG; i++) begin : g_seg
    if (i < NDIG - 1) begin : g_full
      assign seg[7*i +: 7] = blank_low ? 7'h00 : seg7(digits[4*i +: 4]);
    end else begin : g_half
      // half digit: only segments b and c exist
      assign seg[7*i +: 7] = (digits[4*i +: 4] != 4'd0) ? 7'h06 : 7'h00;
    end
  end
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int NDIG         = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int CYCLE_COUNTS = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_trip,
  input  logic              sign_in,
  output logic              ph_az,
  output logic              ph_int,
  output logic              ph_deint,
  output logic [4*NDIG-1:0] digits,
  output logic [7*NDIG-1:0] segs,
  output logic              sign_out,
  output logic              over_range
);
  localparam int TCW = $clog2(CYCLE_COUNTS);
  localparam logic [TCW-1:0] TC_WRAP  = TCW'(CYCLE_COUNTS - 1);
  localparam logic [TCW-1:0] TC_INTE  = TCW'(INT_COUNTS - 1);
  localparam logic [TCW-1:0] TC_DEMAX = TCW'(INT_COUNTS + DEINT_MAX - 1);
  localparam logic [TCW-1:0] TC_RESET = TCW'(INT_COUNTS + DEINT_MAX);
  localparam logic [4*NDIG-1:0] OVR_PAT = {4'd1, {(4*(NDIG-1)){1'b0}}};

  phase_e            phase;
  logic [TCW-1:0]    tc;
  logic              tick;
  logic              clr;
  logic              inc;
  logic [4*NDIG-1:0] bcd;

  dsadc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign clr = tick && ((tc == TC_WRAP) || (phase == PH_INT && tc == TC_INTE));
  assign inc = tick && !clr;

  dsadc_bcd_chain #(.NDIG(NDIG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .val(bcd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_AZ;
      tc         <= TC_RESET;
      digits     <= '0;
      sign_out   <= 1'b0;
      over_range <= 1'b0;
    end else if (tick) begin
      if (tc == TC_WRAP) begin
        tc    <= '0;
        phase <= PH_INT;
      end else begin
        tc <= tc + 1'b1;
        case (phase)
          PH_INT: if (tc == TC_INTE) phase <= PH_DEINT;
          PH_DEINT: begin
            if (cmp_trip) begin
              phase      <= PH_AZ;
              digits     <= bcd;
              over_range <= 1'b0;
              sign_out   <= sign_in;
            end else if (tc == TC_DEMAX) begin
              phase      <= PH_AZ;
              digits     <= OVR_PAT;
              over_range <= 1'b1;
              sign_out   <= sign_in;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ph_az    = (phase == PH_AZ);
  assign ph_int   = (phase == PH_INT);
  assign ph_deint = (phase == PH_DEINT);

  dsadc_seg_bank #(.NDIG(NDIG)) u_seg (
    .digits(digits), .blank_low(over_range), .seg(segs)
  );

  // R2: exactly one switch select active
  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ph_az, ph_int, ph_deint}));
  // R2: de-integrate is entered only from integrate
  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_deint && !$past(ph_deint)) |-> $past(ph_int));
  // R3: integrate begins with a cleared counter chain
  assert_int_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_int && !$past(ph_int)) |-> (bcd == '0));
  // R5: de-integrate never runs beyond its window
  assert_deint_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_deint |-> (tc <= TC_DEMAX));
  // R5: overrange shows the fixed pattern
  assert_ovr_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (digits == OVR_PAT));
  // R7: display only moves at the de-integrate to auto-zero transfer
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_az && $past(ph_deint)) |-> ($stable(digits) && $stable(sign_out) && $stable(over_range)));
endmodule

// File: tb/dsadc_sequencer_bench.sv
module dsadc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_trip = 1'b0;
  logic        sign_in = 1'b0;
  logic        ph_az, ph_int, ph_deint;
  logic [15:0] digits;
  logic [27:0] segs;
  logic        sign_out, over_range;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsadc_sequencer u_dsadc_sequencer (
    .clk(clk), .rst_n(rst_n), .cmp_trip(cmp_trip), .sign_in(sign_in),
    .ph_az(ph_az), .ph_int(ph_int), .ph_deint(ph_deint),
    .digits(digits), .segs(segs), .sign_out(sign_out), .over_range(over_range)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_digits(input int n, input bit ovr);
    if (ovr) return 16'h1000;
    return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [27:0] exp_segs(input int n, input bit ovr);
    if (ovr) return {7'h06, 21'h0};
    return {(n >= 1000) ? 7'h06 : 7'h00, pat((n / 100) % 10), pat((n / 10) % 10), pat(n % 10)};
  endfunction

  int t_int;

  task automatic run_cycle(input int n, input bit ovr, input bit sgn);
    logic [15:0] held_d;
    bit held_s, held_o;
    int t_de, t_az, dur;
    held_d = digits; held_s = sign_out; held_o = over_range;
    while (!ph_deint) begin
      cmp_trip = 1'($urandom); sign_in = 1'($urandom);
      @(negedge clk);
    end
    t_de = cyc;
    chk(t_de - t_int == 4000, "R3 integrate length", t_de - t_int, 4000);
    chk(digits == held_d && sign_out == held_s && over_range == held_o,
        "R7 latch held through integrate", digits, held_d);
    chk({ph_az, ph_int, ph_deint} == 3'b001, "R2 one-hot in de-integrate",
        {ph_az, ph_int, ph_deint}, 3'b001);
    cmp_trip = 1'b0; sign_in = sgn;
    if (!ovr) begin
      repeat (4 * n + 1) @(negedge clk);
      cmp_trip = 1'b1;
    end
    while (!ph_az) @(negedge clk);
    t_az = cyc; cmp_trip = 1'b0;
    dur = ovr ? 8000 : 4 * n + 4;
    if (ovr) begin
      chk(t_az - t_de == dur, "R5 overrange de-integrate length", t_az - t_de, dur);
      chk(over_range == 1'b1, "R5 overrange flag", over_range, 1);
    end else begin
      chk(t_az - t_de == dur, "R4 de-integrate length", t_az - t_de, dur);
      chk(over_range == 1'b0, "R4 no overrange", over_range, 0);
    end
    chk(digits == exp_digits(n, ovr), "R4 R10 latched reading", digits, exp_digits(n, ovr));
    chk(sign_out == sgn, "R8 latched sign", sign_out, sgn);
    chk(segs == exp_segs(n, ovr), "R9 segment patterns", segs, exp_segs(n, ovr));
    held_d = digits; held_s = sign_out; held_o = over_range;
    while (!ph_int) begin
      cmp_trip = 1'($urandom); sign_in = 1'($urandom);
      @(negedge clk);
    end
    chk(cyc - t_int == 16000, "R6 full cycle length", cyc - t_int, 16000);
    chk(cyc - t_az == 16000 - 4000 - dur, "R6 auto-zero absorbs remainder",
        cyc - t_az, 16000 - 4000 - dur);
    chk(digits == held_d && sign_out == held_s && over_range == held_o,
        "R7 latch held through auto-zero", digits, held_d);
    t_int = cyc;
  endtask

  initial begin
    int t_rel;
    void'($urandom(32'h5EED_0A7C));
    repeat (5) @(negedge clk);
    chk(ph_az == 1'b1 && ph_int == 1'b0 && ph_deint == 1'b0, "R1 reset phase",
        {ph_az, ph_int, ph_deint}, 3'b100);
    rst_n = 1'b1;
    t_rel = cyc;
    @(negedge clk);
    chk(digits == 16'h0, "R1 reset digits", digits, 0);
    chk(over_range == 1'b0 && sign_out == 1'b0, "R1 reset flags",
        {over_range, sign_out}, 0);
    chk(segs == {7'h00, 7'h3F, 7'h3F, 7'h3F}, "R1 R9 reset segments",
        segs, {7'h00, 7'h3F, 7'h3F, 7'h3F});
    while (!ph_int) @(negedge clk);
    chk(cyc - t_rel == 4000, "R11 first integrate start", cyc - t_rel, 4000);
    t_int = cyc;
    run_cycle(0, 1'b0, 1'b1);
    run_cycle(1999, 1'b0, 1'b0);
    run_cycle(0, 1'b1, 1'b1);
    run_cycle(1, 1'b0, 1'b0);
    run_cycle(999, 1'b0, 1'b1);
    for (int k = 0; k < 2; k++)
      run_cycle(int'($urandom_range(0, 1999)), 1'b0, 1'($urandom));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule